// File: doc/BRIEF.md
# Microsecond Delay Down-Counter

This block gives a small controller a coarse delay in units of about one microsecond. The controller writes a start count through a register-write port. After that, the count drops by one on every level change of a slow 500 kHz reference square wave. The reference is asynchronous, so it is first brought into the system clock domain through a synchronizer. Because both the rising and the falling transitions count, one step lasts about 1 µs. Each step can be late by up to one system clock period.

An idle output stays high while the count is zero. A controller can stall on that level as a wait event. The write instant has no fixed phase relation to the reference. Loading N therefore guarantees only N−1 full microseconds, so software loads the wanted delay plus one.

An enable input, driven by the power-mode logic, allows counting only in the active and low-power modes. The current count can be read back at any time to see how much delay remains.

Top module: `usec_delay_timer`

## Requirements
- R1: While `rst` is high, and after it is released, `count_o` is 0 and `idle_o` is 1. `rst` is synchronous and active-high.
- R2: When `wr_en_i` is high at a rising clock edge, `count_o` takes the value of `wr_data_i` after that edge. This holds for any 16-bit value, including 16'hFFFF, and whether or not `en_i` is high.
- R3: While `en_i` is high, each transition of `ref_clk_i` (rising or falling) lowers a nonzero count by exactly one. The new value shows on `count_o` after the third rising system clock edge that samples the new reference level. Before that edge the old value is still shown.
- R4: `idle_o` is 1 exactly when `count_o` is 0.
- R5: A reference transition while the count is 0 leaves it at 0. The count never wraps to 16'hFFFF.
- R6: If a write and a decrement fall in the same clock cycle, the written value is loaded and that decrement is lost.
- R7: While `en_i` is low, reference transitions do not change the count. Transitions that happened while disabled are not counted after `en_i` goes high again.
- R8: Writing 0 clears the count at the next clock edge, and `idle_o` is 1 right after that edge.
- R9: When there is no write and no reference transition, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Counting enable from the power-mode logic (1 = active or low-power mode) |
| ref_clk_i | input | 1 | Asynchronous 500 kHz reference square wave |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Start count to load |
| idle_o | output | 1 | High while the count is zero |
| count_o | output | 16 | Current count, for readback |

## Verification
The decrement path is driven in four ways, and each one separates a different fault:
- Runs of a single transition, then alternating transitions. These show whether falling transitions count as well as rising ones, and whether each transition removes exactly one.
- Runs long enough to pass zero. These show the difference between holding at zero and wrapping around.
- Transitions made while the enable is low, followed by one made after it returns. These separate a gated counter from one that catches up on missed transitions.
- A write placed in the exact cycle where a decrement takes effect, and a cycle-by-cycle watch of one transition. These pin down the load priority and the three-edge latency of the synchronizer.

// File: rtl/usec_delay_pkg.sv
package usec_delay_pkg;

    localparam int unsigned CNT_W_DEF       = 16;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_DEC  = 2'd2
    } cnt_op_e;

    // A write wins over a decrement; a decrement at zero becomes a hold.
    function automatic cnt_op_e pick_op(input logic wr, input logic tick, input logic at_zero);
        if (wr) begin
            return OP_LOAD;
        end else if (tick && !at_zero) begin
            return OP_DEC;
        end
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/usec_delay_refsync.sv
module usec_delay_refsync #(
    parameter int unsigned STAGES = usec_delay_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic ref_i,
    output logic tick_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= ref_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // The history flop keeps tracking while disabled, so edges seen then are not replayed later.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign tick_o = en_i & (sync_q[LAST] ^ prev_q);

    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> en_i); // R7

endmodule

// File: rtl/usec_delay_counter.sv
module usec_delay_counter
    import usec_delay_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op_i)
                OP_LOAD: cnt_q <= load_val_i;
                OP_DEC:  cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_LOAD |=> cnt_q == $past(load_val_i)); // R2

endmodule

// File: rtl/usec_delay_timer.sv
module usec_delay_timer
    import usec_delay_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             ref_clk_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             idle_o,
    output logic [CNT_W-1:0] count_o
);
    logic    tick;
    logic    at_zero;
    cnt_op_e op;

    usec_delay_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .ref_i  (ref_clk_i),
        .tick_o (tick)
    );

    assign op = pick_op(wr_en_i, tick, at_zero);

    usec_delay_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .load_val_i (wr_data_i),
        .cnt_o      (count_o),
        .zero_o     (at_zero)
    );

    assign idle_o = at_zero;

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && tick && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && count_o == '0) |=> idle_o); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && tick) |=> count_o == $past(wr_data_i)); // R6
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !wr_en_i) |=> $stable(count_o)); // R7
    AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i == '0) |=> idle_o); // R8
    AST_IDLE_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> count_o == '0); // R4

endmodule

// File: tb/usec_delay_timer_tb_top.sv
`timescale 1ns/1ps
module usec_delay_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b1;
    logic        ref_lvl = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        idle_o;
    logic [15:0] count_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    usec_delay_timer dut_i (
        .clk(clk), .rst(rst), .en_i(en_i), .ref_clk_i(ref_lvl),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .idle_o(idle_o), .count_o(count_o)
    );

    // Vector: kind[33:32] (0 write, 1 enabled transitions, 2 disabled transitions), arg[31:16], expected count[15:0]
    localparam logic [33:0] VEC [10] = '{
        {2'd0, 16'd5,      16'd5},      // R2
        {2'd1, 16'd2,      16'd3},      // R3 rising and falling
        {2'd1, 16'd3,      16'd0},      // R3
        {2'd1, 16'd4,      16'd0},      // R5 no wrap
        {2'd0, 16'hFFFF,   16'hFFFF},   // R2
        {2'd1, 16'd1,      16'hFFFE},   // R3
        {2'd0, 16'd0,      16'd0},      // R8
        {2'd0, 16'h0100,   16'h0100},   // R2
        {2'd2, 16'd5,      16'h0100},   // R7
        {2'd1, 16'd1,      16'h00FF}    // R7 no catch-up
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] v);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic do_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_lvl = ~ref_lvl;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 count in reset", count_o, 16'd0);
        check("R1 idle in reset", {15'd0, idle_o}, 16'd1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 count after reset", count_o, 16'd0);

        for (int k = 0; k < 10; k++) begin
            logic [1:0]  kind;
            logic [15:0] arg;
            logic [15:0] exp;
            kind = VEC[k][33:32];
            arg  = VEC[k][31:16];
            exp  = VEC[k][15:0];
            if (kind == 2'd0) begin
                do_write(arg);
            end else if (kind == 2'd1) begin
                do_edges(int'(arg));
            end else begin
                en_i = 1'b0;
                do_edges(int'(arg));
                repeat (4) @(negedge clk);
                en_i = 1'b1;
                repeat (2) @(negedge clk);
            end
            check("R2/R3/R5/R7 vector count", count_o, exp);
            check("R4 idle vs count", {15'd0, idle_o}, {15'd0, exp == 16'd0});
        end

        // R3 latency: new value only after the third edge
        do_write(16'd10);
        @(negedge clk);
        ref_lvl = ~ref_lvl;
        @(negedge clk);
        @(negedge clk);
        check("R3 before third edge", count_o, 16'd10);
        @(negedge clk);
        check("R3 after third edge", count_o, 16'd9);

        // R6: write lands in the decrement cycle
        repeat (4) @(negedge clk);
        ref_lvl = ~ref_lvl;
        @(negedge clk);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = 16'd40;
        @(negedge clk);
        wr_en_i   = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 write wins", count_o, 16'd40);

        // R9: quiet inputs hold
        repeat (20) @(negedge clk);
        check("R9 hold", count_o, 16'd40);

        // R8: zero write raises idle right after the edge
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = 16'd0;
        @(negedge clk);
        wr_en_i   = 1'b0;
        check("R8 idle after zero write", {15'd0, idle_o}, 16'd1);
        check("R8 count after zero write", count_o, 16'd0);

        // R2: write while disabled still loads
        en_i = 1'b0;
        do_write(16'h1234);
        check("R2 write while disabled", count_o, 16'h1234);
        en_i = 1'b1;

        // R1: reset mid-count
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", count_o, 16'd0);

        finish_run();
    end
endmodule